// File: doc/BRIEF.md
# Memory-Mapped GPIO Port

This block is a byte-wide general-purpose I/O port. A host uses plain single-cycle bus loads and stores to reach it. Each bit position belongs to one physical pin. Three register slots are visible on the bus:

- a direction register, where 1 makes the pin drive and 0 makes it listen;
- a level register, which holds the drive value of an output pin and acts as the pull-up request of an input pin;
- a read-only pad register, which returns the synchronised electrical level seen on the pins.

The port drives three per-pin signals toward the pad ring: an output enable, the drive value and a pull-up enable. The incoming pad levels pass through a two-stage synchroniser before the bus can read them. The pad cells and the resistors are outside the block.

Top module: `gpio_port`

## Requirements
- R1: A write to offset 1 loads the direction register and a write to offset 2 loads the level register. A read at either offset returns the stored byte. The new value is visible from the cycle after the write edge.
- R2: `pin_oe[n]` equals direction bit n, where 1 means output.
- R3: `pin_out[n]` equals level bit n when direction bit n is 1, and is 0 when the pin is an input.
- R4: `pin_pullup[n]` is 1 exactly when direction bit n is 0 and level bit n is 1. It is never 1 on an output pin.
- R5: A read at offset 0 returns `pad_in` as it was sampled two rising edges earlier, through a two-flop synchroniser.
- R6: A read at offset 0 returns the pad level, not the level register, including on pins set as outputs.
- R7: A write to offset 0 changes neither the direction register nor the level register.
- R8: A read at offset 3 returns 0, and a write to offset 3 changes no register.
- R9: `bus_rdata` is 0 in any cycle where `bus_re` is low.
- R10: While `rst` is high at a rising edge, both registers clear, so every pin is an input with no pull-up. Writes in that cycle are dropped.
- R11: Bit n of every register controls or reports pin n only. Writing a one-hot byte affects only that pin's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_re | input | 1 | Read strobe; read data is combinational in the same cycle |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 8 | Asynchronous pad levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin drive value |
| pin_pullup | output | 8 | Per-pin pull-up enable |

## Verification
A register write lands at the rising edge of its cycle. The pin controls, and a read of that register, show the new value one cycle later. Read data is combinational, so a read is checked in the same cycle as its strobe. A pad change reaches offset 0 after two rising edges. The bench keeps a behavioural model that advances at each rising edge and holds the pad history as a queue. It drives inputs just after the falling edge and compares all four outputs against the model one time unit later, in every cycle. Because of this, each result is checked exactly in the cycle where the model says it becomes due.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_pullup
);

  localparam logic [ADDR_W-1:0] OFS_PAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_LVL = ADDR_W'(2);

  logic [WIDTH-1:0] dir_q, lvl_q, meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == OFS_DIR) dir_q <= bus_wdata;
      if (bus_addr == OFS_LVL) lvl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    meta_q <= pad_in;
    sync_q <= meta_q;
  end

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    assign pin_oe[n]     = dir_q[n];
    assign pin_out[n]    = dir_q[n] & lvl_q[n];
    assign pin_pullup[n] = ~dir_q[n] & lvl_q[n];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        OFS_PAD: bus_rdata = sync_q;
        OFS_DIR: bus_rdata = dir_q;
        OFS_LVL: bus_rdata = lvl_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  a_r1_dir_load: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_DIR) |=> pin_oe == $past(bus_wdata));

  a_r1_lvl_load: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_LVL) |=> (pin_out | pin_pullup) == $past(bus_wdata));

  a_r4_no_pull_on_out: assert property (@(posedge clk) disable iff (rst)
    (pin_pullup & pin_oe) == '0);

  a_r5_sync_delay: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2 && bus_re && bus_addr == OFS_PAD) |-> bus_rdata == $past(pad_in, 2));

  a_r7_pad_write_inert: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_PAD) |=> $stable(pin_oe) && $stable(pin_out) && $stable(pin_pullup));

  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(3)) |-> bus_rdata == '0);

  a_r9_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !bus_re |-> bus_rdata == '0);

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> pin_oe == '0 && pin_pullup == '0);

endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 0;
  logic       rst = 1;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_we = 0, bus_re = 0;
  logic [7:0] bus_rdata, pad_in = 0, pin_oe, pin_out, pin_pullup;

  gpio_port i_gpio_port (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] m_dir = 0, m_lvl = 0;
  logic [7:0] pad_hist[$];
  bit cmp_on = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    pad_hist.push_back(pad_in);
    if (pad_hist.size() > 2) void'(pad_hist.pop_front());
    if (rst) begin m_dir = 0; m_lvl = 0; end
    else if (bus_we) begin
      if (bus_addr == 1) m_dir = bus_wdata;
      if (bus_addr == 2) m_lvl = bus_wdata;
    end
  end

  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      logic [7:0] er;
      string rt;
      chk(pin_oe, m_dir, "R2 pin_oe");
      chk(pin_out, m_dir & m_lvl, "R3 pin_out");
      chk(pin_pullup, ~m_dir & m_lvl, "R4 pin_pullup");
      er = 0; rt = "R9 idle rdata";
      if (bus_re) begin
        case (bus_addr)
          0: begin er = pad_hist[0]; rt = "R5 R6 pad rdata"; end
          1: begin er = m_dir; rt = "R1 dir rdata"; end
          2: begin er = m_lvl; rt = "R1 lvl rdata"; end
          default: begin er = 0; rt = "R8 unmapped rdata"; end
        endcase
      end
      chk(bus_rdata, er, rt);
    end
  end

  task automatic cyc(input logic we, input logic re, input logic [1:0] a,
                     input logic [7:0] d, input logic [7:0] pad);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; pad_in = pad;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pv;
    repeat (3) cyc(0, 0, 0, 0, 8'h00);
    cmp_on = 1;
    cyc(0, 1, 1, 0, 8'h00);
    @(negedge clk); #2;
    chk(pin_oe | pin_pullup, 8'h00, "R10 reset state");
    rst = 0;
    cyc(1, 0, 1, 8'hF0, 8'h00);
    cyc(1, 0, 2, 8'hAA, 8'h00);
    cyc(0, 1, 1, 0, 8'h00);
    cyc(0, 1, 2, 0, 8'h00);
    @(negedge clk); #2;
    chk(pin_pullup, 8'h0A, "R4 pullup on inputs only");
    chk(pin_out, 8'hA0, "R3 drive on outputs only");
    cyc(1, 0, 0, 8'hFF, 8'h3C);
    cyc(0, 1, 1, 0, 8'h3C);
    @(negedge clk); #2;
    chk(pin_oe, 8'hF0, "R7 pad write inert dir");
    chk(pin_pullup, 8'h0A, "R7 pad write inert lvl");
    cyc(1, 0, 3, 8'h55, 8'h3C);
    cyc(0, 1, 2, 0, 8'h3C);
    @(negedge clk); #2;
    chk(bus_rdata, 8'hAA, "R8 unmapped write inert");
    cyc(0, 1, 3, 0, 8'h3C);
    for (int k = 0; k < 24; k++) begin
      pv = 8'(k * 37 + 5);
      cyc(0, 1, 0, 0, pv);
    end
    cyc(0, 0, 0, 0, 8'h5A);
    cyc(0, 0, 1, 0, 8'h5A);
    cyc(0, 1, 0, 0, 8'h5A);
    cyc(1, 0, 1, 8'h00, 8'h00);
    cyc(1, 0, 2, 8'h00, 8'h00);
    for (int n = 0; n < 8; n++) begin
      cyc(1, 0, 1, 8'(1 << n), 8'h00);
      cyc(0, 1, 1, 0, 8'h00);
      @(negedge clk); #2;
      chk(pin_oe, 8'(1 << n), "R11 single pin");
    end
    cyc(1, 0, 2, 8'hFF, 8'hFF);
    cyc(0, 1, 0, 0, 8'h00);
    cyc(0, 1, 0, 0, 8'h00);
    cyc(0, 1, 0, 0, 8'h00);
    @(negedge clk); rst = 1; bus_we = 1; bus_addr = 1; bus_wdata = 8'hFF;
    cyc(0, 0, 0, 0, 8'h00);
    @(negedge clk); #2;
    chk(pin_oe | pin_pullup | pin_out, 8'h00, "R10 reset clears, write dropped");
    rst = 0;
    cyc(0, 1, 2, 0, 8'h00);
    cyc(0, 0, 0, 0, 8'h00);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule